// File: doc/BRIEF.md
# DDR2 Command Decoder and Bank State Tracker

This block watches the control pins of a DDR2 SDRAM command bus on each rising clock edge, turns the chip-select, row-strobe, column-strobe and write-enable levels into a compact command code, and keeps a live picture of which of the eight banks hold an open row and which row that is. It is meant to sit beside a memory controller or a bus monitor, giving the rest of the chip a decoded view of the bus without re-deriving the command truth table.

Beyond plain decoding, it applies the state rules that the bus implies. Address bit 10 means "close every bank" on a Precharge and "close after this access" on a Read or Write. A Mode Register Set cycle is steered to one of several register strobes by the bank address. Dropping the clock-enable pin enters a power-down whose kind depends on whether any row is open at that moment. Commands that break the bank rules are flagged and have no effect on the tracked state.

All outputs are registered: a command sampled at one rising edge is reflected on the outputs right after that edge.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: While rst_n is low, bank_open is all zeros, pwr_state is 00 (active standby), cmd is 0, and illegal, auto_pre and mr_wr are all zero.
- R2: With cke high in active standby and cs_n low, the levels {cs_n,ras_n,cas_n,we_n} map to cmd as: 0111 to 0 (NOP), 0011 to 1 (Activate), 0101 to 2 (Read), 0100 to 3 (Write), 0010 to 4 (Precharge), 0001 to 5 (Refresh), 0000 to 6 (Mode Register Set), and 0110 to 0. cmd_bank always shows the sampled bank address.
- R3: When cs_n is sampled high in active standby, cmd is 7 (deselect) and no bank state or strobe changes, whatever ras_n, cas_n and we_n are.
- R4: A legal Activate opens the addressed bank and records the low ROW_W address bits as its open row, shown on open_rows at bit offset bank*ROW_W.
- R5: A Precharge with addr[10] low closes only the addressed bank; with addr[10] high it closes all banks. Precharging a closed bank is legal.
- R6: A legal Read or Write with addr[10] high sets auto_pre and closes the bank; with addr[10] low the bank stays open and auto_pre is 0.
- R7: An Activate to an open bank, or a Read or Write to a closed bank, sets illegal for one cycle and leaves every bank's state unchanged.
- R8: A Refresh is legal only when all banks are closed; otherwise illegal is set.
- R9: A Mode Register Set pulses mr_wr bit ba for one cycle when ba is below NUM_MR (no bit for larger ba) and shows the address on mr_op; bank state is untouched.
- R10: When cke is sampled low in active standby, pwr_state becomes 01 (precharge power-down) if all banks are closed and 10 (active power-down) otherwise; the command on that edge and every edge while cke stays low is ignored (cmd 0, banks held).
- R11: In power-down, the first edge with cke high returns pwr_state to 00 and the command on that edge is ignored; commands take effect from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable pin level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (3) | Bank address |
| addr | input | ADDR_W (14) | Row, column or opcode address |
| cmd | output | 3 | Decoded command code |
| cmd_bank | output | BA_W (3) | Bank address of the last sampled command |
| bank_open | output | NBANK (8) | One open flag per bank |
| open_rows | output | NBANK*ROW_W (112) | Open row of each bank, packed by bank index |
| auto_pre | output | 1 | Legal Read/Write requested close after access |
| illegal | output | 1 | Last command broke the bank rules |
| mr_wr | output | NUM_MR (4) | One-hot mode register write strobe |
| mr_op | output | ADDR_W (14) | Opcode of the last sampled address |
| pwr_state | output | 2 | 00 active standby, 01 precharge power-down, 10 active power-down |

## Verification
The bench builds the block with its defaults: eight banks, 14-bit rows and address, auto-precharge on bit 10 and four mode registers. Eight banks against a 3-bit bank address leave no unused bank codes, while four mode registers leave bank codes 4 to 7 on a Mode Register Set selecting no strobe, so the out-of-range steering case is reachable. The random mix of commands across all eight banks reaches many combinations of partly open bank sets, so power-down entry, Refresh legality and precharge-all are exercised with varied bank populations.

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker #(
  parameter int NBANK  = 8,
  parameter int ROW_W  = 14,
  parameter int ADDR_W = 14,
  parameter int AP_BIT = 10,
  parameter int NUM_MR = 4,
  localparam int BA_W  = $clog2(NBANK)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BA_W-1:0]        ba,
  input  logic [ADDR_W-1:0]      addr,
  output logic [2:0]             cmd,
  output logic [BA_W-1:0]        cmd_bank,
  output logic [NBANK-1:0]       bank_open,
  output logic [NBANK*ROW_W-1:0] open_rows,
  output logic                   auto_pre,
  output logic                   illegal,
  output logic [NUM_MR-1:0]      mr_wr,
  output logic [ADDR_W-1:0]      mr_op,
  output logic [1:0]             pwr_state
);

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD  = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_MRS = 3'd6, C_DES = 3'd7;
  localparam logic [1:0] P_ACT = 2'b00, P_PPD = 2'b01, P_APD = 2'b10;

  logic [2:0] dec;
  always_comb begin
    casez ({cs_n, ras_n, cas_n, we_n})
      4'b1???: dec = C_DES;
      4'b0011: dec = C_ACT;
      4'b0101: dec = C_RD;
      4'b0100: dec = C_WR;
      4'b0010: dec = C_PRE;
      4'b0001: dec = C_REF;
      4'b0000: dec = C_MRS;
      default: dec = C_NOP;
    endcase
  end

  wire live     = cke && (pwr_state == P_ACT);
  wire ap       = addr[AP_BIT];
  wire tgt_open = bank_open[ba];
  wire any_open = |bank_open;
  wire is_rw    = (dec == C_RD) || (dec == C_WR);
  wire bad      = live && (((dec == C_ACT) && tgt_open) ||
                           (is_rw && !tgt_open) ||
                           ((dec == C_REF) && any_open));
  wire go       = live && !bad;

  genvar i;
  generate
    for (i = 0; i < NBANK; i++) begin : g_bank
      wire hit = (ba == BA_W'(i));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          bank_open[i] <= 1'b0;
          open_rows[i*ROW_W +: ROW_W] <= '0;
        end else if (go) begin
          if (dec == C_ACT && hit) begin
            bank_open[i] <= 1'b1;
            open_rows[i*ROW_W +: ROW_W] <= addr[ROW_W-1:0];
          end else if (dec == C_PRE && (ap || hit)) begin
            bank_open[i] <= 1'b0;
          end else if (is_rw && hit && ap) begin
            bank_open[i] <= 1'b0;
          end
        end
      end
    end
    for (i = 0; i < NUM_MR; i++) begin : g_mr
      always_ff @(posedge clk) begin
        if (!rst_n) mr_wr[i] <= 1'b0;
        else        mr_wr[i] <= live && (dec == C_MRS) && (ba == BA_W'(i));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_state <= P_ACT;
      cmd       <= C_NOP;
      cmd_bank  <= '0;
      illegal   <= 1'b0;
      auto_pre  <= 1'b0;
      mr_op     <= '0;
    end else begin
      if (!cke && pwr_state == P_ACT) pwr_state <= any_open ? P_APD : P_PPD;
      else if (cke && pwr_state != P_ACT) pwr_state <= P_ACT;
      cmd      <= live ? dec : C_NOP;
      cmd_bank <= ba;
      illegal  <= bad;
      auto_pre <= go && is_rw && ap;
      mr_op    <= addr;
    end
  end

endmodule

// File: rtl/ddr2_cmd_tracker_chk.sv
module ddr2_cmd_tracker_chk #(
  parameter int NBANK  = 8,
  parameter int NUM_MR = 4,
  localparam int BA_W  = $clog2(NBANK)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [BA_W-1:0]   cmd_bank,
  input logic [NBANK-1:0]  bank_open,
  input logic              auto_pre,
  input logic              illegal,
  input logic [NUM_MR-1:0] mr_wr,
  input logic [1:0]        pwr_state
);

  // R3
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'd7 |-> bank_open == $past(bank_open));

  // R7
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> bank_open == $past(bank_open));

  // R6
  ap_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre |-> (!bank_open[cmd_bank] && (cmd == 3'd2 || cmd == 3'd3)));

  // R9
  mr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mr_wr));

  // R10
  apd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b10 && $past(pwr_state) == 2'b00) |-> bank_open != '0);

  // R10
  ppd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b01 && $past(pwr_state) == 2'b00) |-> bank_open == '0);

  // R10
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'b00 && $past(pwr_state) != 2'b00) |-> $stable(bank_open));

endmodule

bind ddr2_cmd_tracker ddr2_cmd_tracker_chk #(.NBANK(NBANK), .NUM_MR(NUM_MR)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank), .bank_open(bank_open),
  .auto_pre(auto_pre), .illegal(illegal), .mr_wr(mr_wr), .pwr_state(pwr_state)
);

// File: tb/sim_ddr2_cmd_tracker.sv
`timescale 1ns/100ps
module sim_ddr2_cmd_tracker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0] ba = '0;
  logic [13:0] addr = '0;
  logic [2:0] cmd, cmd_bank;
  logic [7:0] bank_open;
  logic [111:0] open_rows;
  logic auto_pre, illegal;
  logic [3:0] mr_wr;
  logic [13:0] mr_op;
  logic [1:0] pwr_state;

  always #2.5 clk = ~clk;

  ddr2_cmd_tracker u0 (.*);

  int n_run = 0, n_fail = 0;
  logic       m_open [8];
  logic [13:0] m_row [8];
  logic [1:0] m_pwr;

  task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [2:0] dec_of(logic [3:0] c);
    if (c[3]) return 3'd7;
    case (c)
      4'b0011: return 3'd1;
      4'b0101: return 3'd2;
      4'b0100: return 3'd3;
      4'b0010: return 3'd4;
      4'b0001: return 3'd5;
      4'b0000: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] d, logic k);
    if (!k) return "R10";
    case (d)
      3'd1: return "R4";
      3'd2, 3'd3: return "R6";
      3'd4: return "R5";
      3'd5: return "R8";
      3'd6: return "R9";
      3'd7: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic step(logic [3:0] c, logic k, logic [2:0] b, logic [13:0] a, string tag);
    logic live, ill, any, eap;
    logic [2:0] d, ecmd;
    logic [3:0] emr;
    logic [7:0] eopen;
    logic [111:0] erows;
    {cs_n, ras_n, cas_n, we_n} = c; cke = k; ba = b; addr = a;
    d = dec_of(c);
    live = k && (m_pwr == 2'b00);
    any = 1'b0;
    for (int i = 0; i < 8; i++) any |= m_open[i];
    ill = live && ((d == 3'd1 && m_open[b]) || ((d == 3'd2 || d == 3'd3) && !m_open[b]) ||
                   (d == 3'd5 && any));
    ecmd = live ? d : 3'd0;
    eap = live && !ill && (d == 3'd2 || d == 3'd3) && a[10];
    emr = '0;
    if (live && d == 3'd6 && b < 4) emr[b[1:0]] = 1'b1;
    if (live && !ill) begin
      case (d)
        3'd1: begin m_open[b] = 1'b1; m_row[b] = a; end
        3'd4: if (a[10]) for (int i = 0; i < 8; i++) m_open[i] = 1'b0;
              else m_open[b] = 1'b0;
        3'd2, 3'd3: if (a[10]) m_open[b] = 1'b0;
        default: ;
      endcase
    end
    if (!k && m_pwr == 2'b00) m_pwr = any ? 2'b10 : 2'b01;
    else if (k && m_pwr != 2'b00) m_pwr = 2'b00;
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      eopen[i] = m_open[i];
      erows[i*14 +: 14] = m_open[i] ? m_row[i] : open_rows[i*14 +: 14];
    end
    check(tag, {cmd, cmd_bank, illegal, auto_pre, mr_wr, pwr_state, bank_open, mr_op},
               {ecmd, b, ill, eap, emr, m_pwr, eopen, a});
    check(tag, open_rows, erows);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin m_open[i] = 1'b0; m_row[i] = '0; end
    m_pwr = 2'b00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {cmd, illegal, auto_pre, mr_wr, pwr_state, bank_open}, '0);
    rst_n = 1'b1;
    step(4'b0111, 1, 3'd0, 14'h0000, "R2");
    step(4'b0110, 1, 3'd1, 14'h0400, "R2");
    step(4'b0011, 1, 3'd2, 14'h1234, "R4");
    step(4'b0011, 1, 3'd2, 14'h0abc, "R7");
    step(4'b0101, 1, 3'd5, 14'h0000, "R7");
    step(4'b0100, 1, 3'd6, 14'h0400, "R7");
    step(4'b1000, 1, 3'd2, 14'h0400, "R3");
    step(4'b1010, 1, 3'd2, 14'h0400, "R3");
    step(4'b0101, 1, 3'd2, 14'h0000, "R6");
    step(4'b0100, 1, 3'd2, 14'h0400, "R6");
    step(4'b0011, 1, 3'd1, 14'h3fff, "R4");
    step(4'b0001, 1, 3'd0, 14'h0000, "R8");
    step(4'b0010, 1, 3'd1, 14'h0000, "R5");
    step(4'b0001, 1, 3'd0, 14'h0000, "R8");
    step(4'b0011, 1, 3'd0, 14'h0001, "R4");
    step(4'b0011, 1, 3'd3, 14'h0002, "R4");
    step(4'b0011, 1, 3'd7, 14'h0003, "R4");
    step(4'b0010, 1, 3'd3, 14'h0000, "R5");
    step(4'b0010, 1, 3'd3, 14'h0000, "R5");
    step(4'b0010, 1, 3'd5, 14'h0400, "R5");
    step(4'b0000, 1, 3'd1, 14'h0a53, "R9");
    step(4'b0000, 1, 3'd6, 14'h0042, "R9");
    step(4'b0011, 0, 3'd4, 14'h0010, "R10");
    step(4'b0011, 0, 3'd4, 14'h0010, "R10");
    step(4'b0011, 1, 3'd4, 14'h0010, "R11");
    step(4'b0011, 1, 3'd4, 14'h0011, "R4");
    step(4'b0010, 0, 3'd4, 14'h0400, "R10");
    step(4'b0111, 0, 3'd4, 14'h0400, "R10");
    step(4'b0010, 1, 3'd4, 14'h0400, "R11");
    step(4'b0101, 1, 3'd4, 14'h0000, "R11");
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] c;
      logic k;
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 7));
      case (pick)
        3'd0: c = 4'b0011;
        3'd1: c = 4'b0011;
        3'd2: c = 4'b0101;
        3'd3: c = 4'b0100;
        3'd4: c = 4'b0010;
        3'd5: c = ($urandom_range(0, 1) != 0) ? 4'b0001 : 4'b0000;
        3'd6: c = {1'b1, 3'($urandom())};
        default: c = 4'b0111;
      endcase
      k = ($urandom_range(0, 19) != 0);
      step(c, k, 3'($urandom()), 14'($urandom()), tag_of(dec_of(c), k));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule